// File: doc/BRIEF.md
# Table-Based UART Bit-Clock Divider

This block derives two independent oversampling strobes, one for the receive side of a UART and one for the transmit side, from a single core clock. An 8-bit selection register holds two 4-bit codes, and each code picks one of sixteen fixed, non-uniformly spaced divide ratios. The serial bit rate of a direction is the core clock divided by its selected ratio. The strobes run at sixteen times that bit rate, so each direction's counter wraps after the ratio divided by sixteen core cycles.

Software programs the selection through a single write strobe with an 8-bit data word. A write restarts both counters from the new selection, so neither strobe emits a short or stray pulse when the rate changes. After reset the register selects a ratio of 64 for both directions, which gives 115200 baud from a 7.3728 MHz core clock.

Top module: `baud_divider`

## Requirements
- R1: While reset is held and in the cycle after it, `sel_q` reads 8'hCC and both `rx_tick` and `tx_tick` are low.
- R2: A cycle with `sel_wr` high loads `sel_wdata` into `sel_q`, visible in the next cycle; with `sel_wr` low, `sel_q` holds its value whatever `sel_wdata` carries.
- R3: The receive code is `sel_q[7:4]` and the transmit code is `sel_q[3:0]`; code c selects the ratio 24576, 12288, 6144, 3072, 1536, 768, 512, 384, 256, 192, 128, 96, 64, 48, 32, 16 for c = 0, 1, ..., 15 in that order, and the strobe of that direction repeats every ratio/16 core cycles.
- R4: Each strobe is high for exactly one core cycle per period; only when the period is one cycle (code 15) does it stay high continuously.
- R5: A write reloads both counters: both strobes are low in the cycle after the write edge, and each first rises P core cycles after the write edge, P being its new period.
- R6: The two directions count independently; different receive and transmit codes produce their two periods at the same time.
- R7: The first strobe of each direction after reset rises P cycles after the last clock edge with reset high, P being the period of code 12 (4 cycles).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Write strobe for the selection register |
| sel_wdata | input | 8 | New selection: receive code in [7:4], transmit code in [3:0] |
| sel_q | output | 8 | Current selection register contents |
| rx_tick | output | 1 | Receive oversampling strobe, one core cycle wide |
| tx_tick | output | 1 | Transmit oversampling strobe, one core cycle wide |

## Verification
The bench builds the block with its default sixteen-times oversampling and the 8'hCC reset selection, so the strobe periods range from one core cycle (code 15) up to 1536 cycles (code 0). That span is short enough to sweep every one of the sixteen codes in each direction, both with the two directions on opposite codes and on the same code, comparing every cycle of two full periods against a period computed from the ratio table. The one-cycle period reaches the continuous-strobe corner, and rewrites in the middle of a long count expose any stale reload.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

  localparam int CODE_W    = 4;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int SEL_W     = 2 * CODE_W;
  localparam int RATIO_W   = 15;
  localparam int MAX_OSR_LOG2 = 4;

  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  // Fixed divide ratio for each selector code.
  function automatic ratio_t ratio_of(input code_t code);
    ratio_t r;
    case (code)
      4'd0:    r = 15'd24576;
      4'd1:    r = 15'd12288;
      4'd2:    r = 15'd6144;
      4'd3:    r = 15'd3072;
      4'd4:    r = 15'd1536;
      4'd5:    r = 15'd768;
      4'd6:    r = 15'd512;
      4'd7:    r = 15'd384;
      4'd8:    r = 15'd256;
      4'd9:    r = 15'd192;
      4'd10:   r = 15'd128;
      4'd11:   r = 15'd96;
      4'd12:   r = 15'd64;
      4'd13:   r = 15'd48;
      4'd14:   r = 15'd32;
      default: r = 15'd16;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/baud_sel_reg.sv
module baud_sel_reg #(
  parameter int          WIDTH     = 8,
  parameter logic [7:0]  RESET_VAL = 8'hCC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= WIDTH'(RESET_VAL);
    end else if (wr) begin
      q <= wdata;
    end
  end

endmodule

// File: rtl/baud_period_lut.sv
module baud_period_lut
  import baud_div_pkg::*;
#(
  parameter int OSR_LOG2 = 4,
  parameter int CNT_W    = 11
) (
  input  code_t            code,
  output logic [CNT_W-1:0] reload
);

  ratio_t ratio;
  ratio_t period;

  always_comb begin
    ratio  = ratio_of(code);
    period = ratio >> OSR_LOG2;
    reload = CNT_W'(period - ratio_t'(1));
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (load) begin
      cnt  <= reload;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= reload;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/baud_divider.sv
module baud_divider
  import baud_div_pkg::*;
#(
  parameter int         OSR_LOG2  = 4,
  parameter logic [7:0] SEL_RESET = 8'hCC
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_wr,
  input  logic [7:0] sel_wdata,
  output logic [7:0] sel_q,
  output logic       rx_tick,
  output logic       tx_tick
);

  localparam int OSR_EFF    = (OSR_LOG2 > MAX_OSR_LOG2) ? MAX_OSR_LOG2 :
                              ((OSR_LOG2 < 0) ? 0 : OSR_LOG2);
  localparam int MAX_PERIOD = 24576 >> OSR_EFF;
  localparam int CNT_W      = (MAX_PERIOD > 1) ? $clog2(MAX_PERIOD) : 1;
  localparam int NUM_DIR    = 2;

  logic [SEL_W-1:0] sel_cur;
  logic [NUM_DIR-1:0] ticks;

  baud_sel_reg #(
    .WIDTH     (SEL_W),
    .RESET_VAL (SEL_RESET)
  ) u_sel (
    .clk   (clk),
    .rst   (rst),
    .wr    (sel_wr),
    .wdata (sel_wdata),
    .q     (sel_cur)
  );

  // Direction 0 is receive (upper nibble), direction 1 is transmit.
  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    localparam int LSB = (d == 0) ? CODE_W : 0;

    code_t            code_next;
    logic [CNT_W-1:0] reload;

    always_comb begin
      if (rst) begin
        code_next = SEL_RESET[LSB +: CODE_W];
      end else if (sel_wr) begin
        code_next = sel_wdata[LSB +: CODE_W];
      end else begin
        code_next = sel_cur[LSB +: CODE_W];
      end
    end

    baud_period_lut #(
      .OSR_LOG2 (OSR_EFF),
      .CNT_W    (CNT_W)
    ) u_lut (
      .code   (code_next),
      .reload (reload)
    );

    baud_tick_gen #(
      .CNT_W (CNT_W)
    ) u_gen (
      .clk    (clk),
      .load   (rst | sel_wr),
      .reload (reload),
      .tick   (ticks[d])
    );
  end

  assign sel_q   = sel_cur;
  assign rx_tick = ticks[0];
  assign tx_tick = ticks[1];

endmodule

// File: rtl/baud_divider_checker.sv
module baud_divider_checker
  import baud_div_pkg::*;
#(
  parameter int         OSR_LOG2  = 4,
  parameter logic [7:0] SEL_RESET = 8'hCC
) (
  input logic       clk,
  input logic       rst,
  input logic       sel_wr,
  input logic [7:0] sel_wdata,
  input logic [7:0] sel_q,
  input logic       rx_tick,
  input logic       tx_tick
);

  localparam int OSR_EFF = (OSR_LOG2 > MAX_OSR_LOG2) ? MAX_OSR_LOG2 :
                           ((OSR_LOG2 < 0) ? 0 : OSR_LOG2);

  logic [15:0] rx_per, tx_per;
  logic [15:0] rx_gap, tx_gap;
  logic        rst_q    = 1'b0;
  logic        seen_rst = 1'b0;

  always_comb begin
    rx_per = 16'(ratio_of(sel_q[7:4]) >> OSR_EFF);
    tx_per = 16'(ratio_of(sel_q[3:0]) >> OSR_EFF);
  end

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) seen_rst <= 1'b1;
    if (rst || sel_wr || rx_tick) rx_gap <= '0;
    else                          rx_gap <= rx_gap + 1'b1;
    if (rst || sel_wr || tx_tick) tx_gap <= '0;
    else                          tx_gap <= tx_gap + 1'b1;
  end

  always @(posedge clk) begin
    if (rst_q) begin
      p_reset_state_r1: assert (sel_q == SEL_RESET && !rx_tick && !tx_tick)
        else $error("reset state wrong");
    end
    if (seen_rst && !rst) begin
      p_gap_rx_r3: assert (rx_gap <= rx_per) else $error("rx gap too long");
      p_gap_tx_r3: assert (tx_gap <= tx_per) else $error("tx gap too long");
      p_due_rx_r3: assert (rx_gap != rx_per || rx_tick) else $error("rx tick missing");
      p_due_tx_r3: assert (tx_gap != tx_per || tx_tick) else $error("tx tick missing");
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> sel_q == $past(sel_wdata));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !sel_wr |=> $stable(sel_q));

  p_quiet_after_write_r5: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> (!rx_tick && !tx_tick));

  p_single_rx_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_tick && rx_per != 16'd1) |=> !rx_tick);

  p_single_tx_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_tick && tx_per != 16'd1) |=> !tx_tick);

endmodule

bind baud_divider baud_divider_checker #(
  .OSR_LOG2  (OSR_LOG2),
  .SEL_RESET (SEL_RESET)
) u_chk (.*);

// File: tb/baud_divider_bench.sv
module baud_divider_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_wr = 1'b0;
  logic [7:0] sel_wdata = 8'h00;
  logic [7:0] sel_q;
  logic       rx_tick, tx_tick;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  baud_divider u_baud_divider (
    .clk       (clk),
    .rst       (rst),
    .sel_wr    (sel_wr),
    .sel_wdata (sel_wdata),
    .sel_q     (sel_q),
    .rx_tick   (rx_tick),
    .tx_tick   (tx_tick)
  );

  // Ratio table rebuilt arithmetically from its pattern.
  function automatic int exp_ratio(input int code);
    if (code <= 5)  return 24576 >> code;
    if (code <= 13) return (((code - 6) % 2) == 0) ? (512 >> ((code - 6) / 2))
                                                   : (384 >> ((code - 6) / 2));
    if (code == 14) return 32;
    return 16;
  endfunction

  function automatic int exp_period(input int code);
    return exp_ratio(code) / 16;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at the negedge just after the anchor edge (write or last reset edge).
  task automatic run_window(input int prx, input int ptx, input string req);
    int n = 2 * ((prx > ptx) ? prx : ptx) + 2;
    int bad_rx = 0, bad_tx = 0;
    int k_rx = -1, k_tx = -1;
    int a_rx = 0, a_tx = 0;
    check(rx_tick == 1'b0 && tx_tick == 1'b0, "R5", "strobe right after anchor",
          int'(rx_tick) + int'(tx_tick), 0);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (rx_tick !== ((k % prx) == 0)) begin
        if (bad_rx == 0) begin k_rx = k; a_rx = int'(rx_tick); end
        bad_rx++;
      end
      if (tx_tick !== ((k % ptx) == 0)) begin
        if (bad_tx == 0) begin k_tx = k; a_tx = int'(tx_tick); end
        bad_tx++;
      end
    end
    check(bad_rx == 0, req, $sformatf("rx period %0d first bad cycle %0d", prx, k_rx),
          a_rx, (k_rx >= 0 && (k_rx % prx) == 0) ? 1 : 0);
    check(bad_tx == 0, req, $sformatf("tx period %0d first bad cycle %0d", ptx, k_tx),
          a_tx, (k_tx >= 0 && (k_tx % ptx) == 0) ? 1 : 0);
  endtask

  task automatic write_sel(input logic [7:0] v);
    sel_wr    = 1'b1;
    sel_wdata = v;
    @(posedge clk);
    @(negedge clk);
    sel_wr    = 1'b0;
    check(sel_q == v, "R2", "sel_q after write", int'(sel_q), int'(v));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sel_q == 8'hCC && !rx_tick && !tx_tick, "R1", "state during reset",
          int'(sel_q), 8'hCC);
    rst = 1'b0;
    // R7: default code 12 gives period 4 on both sides from the last reset edge.
    check(sel_q == 8'hCC, "R1", "sel_q after reset", int'(sel_q), 8'hCC);
    sel_wdata = 8'h00;
    run_window(4, 4, "R7");
    // R2: data without strobe is ignored.
    check(sel_q == 8'hCC, "R2", "sel_q held without strobe", int'(sel_q), 8'hCC);

    // R3/R6: opposite codes on the two sides.
    for (int i = 0; i < 16; i++) begin
      write_sel(8'((i << 4) | (15 - i)));
      run_window(exp_period(i), exp_period(15 - i), "R3 R6");
    end

    // R3/R4: same code on both sides, including continuous code 15.
    for (int i = 0; i < 16; i++) begin
      write_sel(8'((i << 4) | i));
      run_window(exp_period(i), exp_period(i), "R3 R4");
    end

    // R5: rewrite in the middle of a long count.
    write_sel(8'h00);
    repeat (700) @(negedge clk);
    check(!rx_tick && !tx_tick, "R5", "no strobe mid count", int'(rx_tick), 0);
    write_sel(8'h4E);
    run_window(exp_period(4), exp_period(14), "R5");
    write_sel(8'hF0);
    repeat (5) @(negedge clk);
    write_sel(8'hCD);
    run_window(exp_period(12), exp_period(13), "R5");

    // R1/R7: reset in the middle of operation restores the default.
    write_sel(8'h39);
    repeat (17) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(sel_q == 8'hCC, "R1", "sel_q after second reset", int'(sel_q), 8'hCC);
    run_window(4, 4, "R7");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule